// File: doc/BRIEF.md
# Mailbox Doorbell Console Link

This block carries a character console between two bus masters, called the host side and the local side. Each direction has one 32-bit mailbox and one doorbell register. The sender loads a character into its mailbox with bit 31 set, so that a zero byte still shows the mailbox as occupied. It then sets a message code in the doorbell. The doorbell raises an interrupt toward the receiver.

Mailbox occupancy is the only handshake in each direction. A sender may load its mailbox only while the mailbox reads zero. On the local side, a receive engine services the inbound doorbell. The engine answers liveness probes, restarts the link on a connect message, and stores received bytes in a circular buffer. When that buffer is nearly full, the engine leaves the inbound mailbox occupied, which stalls the host until the local consumer drains some bytes.

The receive engine is a three-state machine:
- **ST_IDLE** waits for a nonzero inbound doorbell. The transition *take* moves it to ST_DECODE and latches the code.
- **ST_DECODE** performs the action for the latched code. The transition *act* moves it to ST_ACK.
- **ST_ACK** clears the whole inbound doorbell with an all-ones write-one-to-clear. The transition *done* returns it to ST_IDLE.

Top module: `dbl_console_link`

## Requirements
- R1: `loc_tx_ready` is high exactly when the outbound mailbox (`host_rx_mb`) reads zero. Holding `loc_tx_valid` while ready loads the mailbox with `0x80000000 | char` and sets the DATA code `0x5` in the outbound doorbell (`host_rx_db`). While the mailbox is nonzero, a local send leaves it unchanged.
- R2: An inbound doorbell code of `0x1` (ALIVE) makes the engine set `0x1` in the outbound doorbell.
- R3: An inbound code of `0x2` (CONNECT) empties the receive buffer (`loc_rd_avail` drops), clears the hold state and zeroes the inbound mailbox.
- R4: An inbound code of `0x5` (DATA) appends bits 7:0 of the inbound mailbox to the circular buffer of DEPTH (256) bytes. Bytes leave in arrival order on `loc_rd_data` while `loc_rd_avail` is high; one byte leaves per cycle of `loc_rd_en`. The pointers wrap around the buffer end.
- R5: After a DATA message, the inbound mailbox is zeroed if occupancy is at most DEPTH-4 (252). If occupancy exceeds 252, the mailbox is held nonzero and a hold flag is set.
- R6: While the hold flag is set, a consumer read that leaves occupancy below 252 clears the flag and zeroes the inbound mailbox. A read that leaves exactly 252 does not.
- R7: `loc_ics` bit 20 shows a pending inbound doorbell, and `loc_irq` is that bit ANDed with `loc_irq_en`. The engine clears the inbound doorbell after servicing it.
- R8: The host clears outbound doorbell bits by writing ones to them. `host_irq` is the OR of the outbound doorbell bits ANDed with `host_irq_en`.
- R9: Any other inbound code is acknowledged and has no effect on the buffer or the mailbox. It sets the sticky `proto_err` flag.
- R10: After reset, both mailboxes and both doorbells are zero, the buffer is empty, `proto_err` is low and `loc_tx_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_mb_we | input | 1 | Host write strobe for the inbound mailbox |
| host_mb_wdata | input | 32 | Host data for the inbound mailbox |
| host_mb_rdata | output | 32 | Inbound mailbox contents, read back by the host |
| host_db_we | input | 1 | Host write-one-to-set strobe for the inbound doorbell |
| host_db_wdata | input | 32 | Bits to set in the inbound doorbell |
| host_rx_mb | output | 32 | Outbound mailbox (local to host) |
| host_rx_clr | input | 1 | Host zeroes the outbound mailbox |
| host_rx_db | output | 32 | Outbound doorbell |
| host_ack_we | input | 1 | Host write-one-to-clear strobe for the outbound doorbell |
| host_ack_wdata | input | 32 | Bits to clear in the outbound doorbell |
| host_irq_en | input | 1 | Host interrupt enable |
| host_irq | output | 1 | Host interrupt |
| loc_tx_valid | input | 1 | Local character send request |
| loc_tx_char | input | 8 | Local character to send |
| loc_tx_ready | output | 1 | Outbound mailbox is empty |
| loc_rd_en | input | 1 | Consumer pops one received byte |
| loc_rd_data | output | 8 | Oldest received byte |
| loc_rd_avail | output | 1 | Receive buffer is not empty |
| loc_irq_en | input | 1 | Local interrupt enable |
| loc_irq | output | 1 | Local interrupt |
| loc_ics | output | 32 | Local interrupt status; bit 20 is the inbound doorbell |
| proto_err | output | 1 | Sticky flag for an unknown message code |

## Verification
A host doorbell write lands on clock edge E. The engine latches the code on E+1 and performs the action on E+2 (buffer write, mailbox zeroing, ALIVE reply). It clears the doorbell on E+3.

A local send and a consumer read take effect on the same edge that accepts them. This includes the release of a held mailbox.

The bench drives inputs one time unit after a rising edge and samples on falling edges. After each doorbell it polls `loc_ics` bit 20 until the bit drops, so every engine result is already registered when it is checked. A scoreboard queue holds the bytes the host sent. A monitor compares each popped byte against the queue on the falling edge before the pop takes effect.

// File: rtl/dbl_pkg.sv
package dbl_pkg;
    localparam logic [31:0] MSG_ALIVE   = 32'h1;
    localparam logic [31:0] MSG_CONNECT = 32'h2;
    localparam logic [31:0] MSG_DISCON  = 32'h3;
    localparam logic [31:0] MSG_DATA    = 32'h5;
    localparam int unsigned ICS_DB_BIT  = 20;
    localparam logic [31:0] TX_MARK     = 32'h8000_0000;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECODE,
        ST_ACK
    } eng_state_e;
endpackage

// File: rtl/dbl_doorbell.sv
module dbl_doorbell #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_we,
    input  logic [W-1:0] set_bits,
    input  logic         clr_we,
    input  logic [W-1:0] clr_bits,
    output logic [W-1:0] bell_q
);
    logic [W-1:0] set_m, clr_m;

    assign set_m = set_we ? set_bits : '0;
    assign clr_m = clr_we ? clr_bits : '0;

    // a bit being set in the same cycle survives a clear
    always_ff @(posedge clk) begin
        if (!rst_n) bell_q <= '0;
        else        bell_q <= (bell_q & ~clr_m) | set_m;
    end
endmodule

// File: rtl/dbl_rx_ring.sv
module dbl_rx_ring #(
    parameter int DEPTH  = 256,
    parameter int MARGIN = 4,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic          avail_o,
    output logic          free_o
);
    localparam int AW  = $clog2(DEPTH);
    localparam int CW  = AW + 1;
    localparam int THR = DEPTH - MARGIN;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          hold_q, hold_d;
    logic          do_push, do_pop;

    assign do_push = push_i && (cnt_q != CW'(DEPTH));
    assign do_pop  = pop_i && (cnt_q != '0);
    assign cnt_d   = cnt_q + CW'(do_push) - CW'(do_pop);
    assign head_o  = mem[rp_q];
    assign avail_o = (cnt_q != '0);

    always_comb begin
        hold_d = hold_q;
        free_o = 1'b0;
        if (clr_i) begin
            hold_d = 1'b0;
        end else if (do_push) begin
            if (cnt_d > CW'(THR)) hold_d = 1'b1;
            else                  free_o = 1'b1;
        end else if (do_pop && hold_q && (cnt_d < CW'(THR))) begin
            hold_d = 1'b0;
            free_o = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !clr_i) mem[wp_q] <= push_data_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            wp_q   <= '0;
            rp_q   <= '0;
            cnt_q  <= '0;
            hold_q <= 1'b0;
        end else begin
            if (do_push) wp_q <= (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
            if (do_pop)  rp_q <= (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
            cnt_q  <= cnt_d;
            hold_q <= hold_d;
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> (cnt_q < CW'(DEPTH))); // R4
    AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_q && !pop_i && !clr_i) |=> hold_q); // R5
endmodule

// File: rtl/dbl_rx_engine.sv
module dbl_rx_engine
    import dbl_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] bell_i,
    output logic        push_o,
    output logic        ring_clr_o,
    output logic        mb_zero_o,
    output logic        alive_o,
    output logic        ack_o,
    output logic        err_o
);
    eng_state_e  state_q, state_d;
    logic [31:0] code_q;
    logic        bad;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (bell_i != '0) state_d = ST_DECODE;  // take
            ST_DECODE: state_d = ST_ACK;                       // act
            ST_ACK:    state_d = ST_IDLE;                      // done
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                                code_q <= '0;
        else if (state_q == ST_IDLE && bell_i != '0) code_q <= bell_i;
    end

    always_comb begin
        push_o     = 1'b0;
        ring_clr_o = 1'b0;
        mb_zero_o  = 1'b0;
        alive_o    = 1'b0;
        ack_o      = 1'b0;
        bad        = 1'b0;
        unique case (state_q)
            ST_DECODE: begin
                if (code_q == MSG_ALIVE)        alive_o = 1'b1;
                else if (code_q == MSG_CONNECT) begin
                    ring_clr_o = 1'b1;
                    mb_zero_o  = 1'b1;
                end
                else if (code_q == MSG_DATA)    push_o = 1'b1;
                else                            bad    = 1'b1;
            end
            ST_ACK:  ack_o = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   err_o <= 1'b0;
        else if (bad) err_o <= 1'b1;
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o); // R9
endmodule

// File: rtl/dbl_console_link.sv
module dbl_console_link
    import dbl_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int MARGIN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_mb_we,
    input  logic [31:0] host_mb_wdata,
    output logic [31:0] host_mb_rdata,
    input  logic        host_db_we,
    input  logic [31:0] host_db_wdata,
    output logic [31:0] host_rx_mb,
    input  logic        host_rx_clr,
    output logic [31:0] host_rx_db,
    input  logic        host_ack_we,
    input  logic [31:0] host_ack_wdata,
    input  logic        host_irq_en,
    output logic        host_irq,
    input  logic        loc_tx_valid,
    input  logic [7:0]  loc_tx_char,
    output logic        loc_tx_ready,
    input  logic        loc_rd_en,
    output logic [7:0]  loc_rd_data,
    output logic        loc_rd_avail,
    input  logic        loc_irq_en,
    output logic        loc_irq,
    output logic [31:0] loc_ics,
    output logic        proto_err
);
    logic [31:0] in_mb_q, in_bell, out_set;
    logic        e_push, e_rclr, e_mbz, e_alive, e_ack;
    logic        r_free, tx_fire;

    dbl_doorbell #(.W(32)) i_in_bell (
        .clk(clk), .rst_n(rst_n),
        .set_we(host_db_we), .set_bits(host_db_wdata),
        .clr_we(e_ack), .clr_bits('1),
        .bell_q(in_bell)
    );

    assign tx_fire = loc_tx_valid && loc_tx_ready;
    assign out_set = (tx_fire ? MSG_DATA : '0) | (e_alive ? MSG_ALIVE : '0);

    dbl_doorbell #(.W(32)) i_out_bell (
        .clk(clk), .rst_n(rst_n),
        .set_we(tx_fire || e_alive), .set_bits(out_set),
        .clr_we(host_ack_we), .clr_bits(host_ack_wdata),
        .bell_q(host_rx_db)
    );

    dbl_rx_engine i_engine (
        .clk(clk), .rst_n(rst_n), .bell_i(in_bell),
        .push_o(e_push), .ring_clr_o(e_rclr), .mb_zero_o(e_mbz),
        .alive_o(e_alive), .ack_o(e_ack), .err_o(proto_err)
    );

    dbl_rx_ring #(.DEPTH(DEPTH), .MARGIN(MARGIN), .DW(8)) i_ring (
        .clk(clk), .rst_n(rst_n), .clr_i(e_rclr),
        .push_i(e_push), .push_data_i(in_mb_q[7:0]),
        .pop_i(loc_rd_en), .head_o(loc_rd_data),
        .avail_o(loc_rd_avail), .free_o(r_free)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                in_mb_q <= '0;
        else if (host_mb_we)       in_mb_q <= host_mb_wdata;
        else if (r_free || e_mbz)  in_mb_q <= '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)           host_rx_mb <= '0;
        else if (host_rx_clr) host_rx_mb <= '0;
        else if (tx_fire)     host_rx_mb <= TX_MARK | {24'h0, loc_tx_char};
    end

    assign host_mb_rdata = in_mb_q;
    assign loc_tx_ready  = (host_rx_mb == '0);
    assign host_irq      = host_irq_en && (host_rx_db != '0);

    always_comb begin
        loc_ics             = '0;
        loc_ics[ICS_DB_BIT] = (in_bell != '0);
    end
    assign loc_irq = loc_irq_en && loc_ics[ICS_DB_BIT];

    AST_TX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_tx_valid && host_rx_mb != '0 && !host_rx_clr) |=> $stable(host_rx_mb)); // R1
    AST_BELL_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (e_ack && !host_db_we) |=> (in_bell == '0)); // R7
endmodule

// File: tb/test_dbl_console_link.sv
module test_dbl_console_link;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_mb_we = 0, host_db_we = 0, host_rx_clr = 0, host_ack_we = 0;
    logic [31:0] host_mb_wdata = '0, host_db_wdata = '0, host_ack_wdata = '0;
    logic        host_irq_en = 1, loc_tx_valid = 0, loc_rd_en = 0, loc_irq_en = 1;
    logic [7:0]  loc_tx_char = '0;
    logic [31:0] host_mb_rdata, host_rx_mb, host_rx_db, loc_ics;
    logic        host_irq, loc_tx_ready, loc_rd_avail, loc_irq, proto_err;
    logic [7:0]  loc_rd_data;

    int n_chk = 0, n_bad = 0;
    bit ended = 0;
    logic [7:0] sb_q[$];

    always #2 clk = ~clk;

    dbl_console_link i_dbl_console_link (
        .clk(clk), .rst_n(rst_n),
        .host_mb_we(host_mb_we), .host_mb_wdata(host_mb_wdata), .host_mb_rdata(host_mb_rdata),
        .host_db_we(host_db_we), .host_db_wdata(host_db_wdata),
        .host_rx_mb(host_rx_mb), .host_rx_clr(host_rx_clr), .host_rx_db(host_rx_db),
        .host_ack_we(host_ack_we), .host_ack_wdata(host_ack_wdata),
        .host_irq_en(host_irq_en), .host_irq(host_irq),
        .loc_tx_valid(loc_tx_valid), .loc_tx_char(loc_tx_char), .loc_tx_ready(loc_tx_ready),
        .loc_rd_en(loc_rd_en), .loc_rd_data(loc_rd_data), .loc_rd_avail(loc_rd_avail),
        .loc_irq_en(loc_irq_en), .loc_irq(loc_irq), .loc_ics(loc_ics), .proto_err(proto_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    // monitor: compare every accepted pop with the scoreboard
    always @(negedge clk) begin
        if (rst_n && loc_rd_en && loc_rd_avail) begin
            if (sb_q.size() == 0) chk(0, "R4 pop with empty scoreboard", {24'h0, loc_rd_data}, 32'h0);
            else begin
                logic [7:0] e;
                e = sb_q.pop_front();
                chk(loc_rd_data == e, "R4 byte order", {24'h0, loc_rd_data}, {24'h0, e});
            end
        end
    end

    task automatic h_bell(input logic [31:0] code);
        host_db_we = 1; host_db_wdata = code; cyc();
        host_db_we = 0;
        for (int k = 0; k < 20 && loc_ics[20]; k++) cyc();
    endtask

    task automatic h_send(input logic [7:0] b);
        for (int k = 0; k < 100 && host_mb_rdata != 0; k++) cyc();
        host_mb_we = 1; host_mb_wdata = 32'h8000_0000 | {24'h0, b}; cyc();
        host_mb_we = 0;
        sb_q.push_back(b);
        h_bell(32'h5);
    endtask

    task automatic pop_n(input int n);
        loc_rd_en = 1;
        repeat (n) cyc();
        loc_rd_en = 0;
    endtask

    initial begin
        #(4 * 150000);
        chk(0, "watchdog", 32'h0, 32'h1);
        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        repeat (3) cyc();
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk(loc_tx_ready == 1, "R10 tx ready", {31'h0, loc_tx_ready}, 32'h1);
        chk(loc_rd_avail == 0, "R10 buffer empty", {31'h0, loc_rd_avail}, 32'h0);
        chk(host_rx_db == 0 && host_irq == 0, "R10 out bell", host_rx_db, 32'h0);
        chk(host_mb_rdata == 0 && host_rx_mb == 0, "R10 mailboxes", host_mb_rdata | host_rx_mb, 32'h0);
        chk(proto_err == 0 && loc_irq == 0, "R10 err/irq", {30'h0, proto_err, loc_irq}, 32'h0);

        // R7 pending bit and local irq
        cyc();
        host_db_we = 1; host_db_wdata = 32'h1; cyc(); host_db_we = 0;
        @(negedge clk);
        chk(loc_ics[20] == 1 && loc_irq == 1, "R7 pending", loc_ics, 32'h0010_0000);
        cyc();
        for (int k = 0; k < 20 && loc_ics[20]; k++) cyc();
        @(negedge clk);
        chk(loc_ics == 0, "R7 engine acked", loc_ics, 32'h0);
        // R2 alive reply
        chk(host_rx_db == 32'h1, "R2 alive reply", host_rx_db, 32'h1);
        chk(host_irq == 1, "R8 host irq", {31'h0, host_irq}, 32'h1);
        cyc();
        host_irq_en = 0; cyc();
        @(negedge clk);
        chk(host_irq == 0, "R8 irq gated", {31'h0, host_irq}, 32'h0);
        cyc();
        host_irq_en = 1; host_ack_we = 1; host_ack_wdata = 32'hFFFF_FFFF; cyc(); host_ack_we = 0;
        @(negedge clk);
        chk(host_rx_db == 0 && host_irq == 0, "R8 w1c ack", host_rx_db, 32'h0);

        // R1 local send of a zero byte
        cyc();
        loc_tx_valid = 1; loc_tx_char = 8'h00; cyc();
        loc_tx_char = 8'h41; cyc(); cyc();
        loc_tx_valid = 0;
        @(negedge clk);
        chk(host_rx_mb == 32'h8000_0000, "R1 mailbox marked, busy held", host_rx_mb, 32'h8000_0000);
        chk(host_rx_db == 32'h5, "R1 data bell", host_rx_db, 32'h5);
        chk(loc_tx_ready == 0, "R1 not ready", {31'h0, loc_tx_ready}, 32'h0);
        cyc();
        host_rx_clr = 1; cyc(); host_rx_clr = 0;
        host_ack_we = 1; host_ack_wdata = 32'hFFFF_FFFF; cyc(); host_ack_we = 0;
        @(negedge clk);
        chk(loc_tx_ready == 1, "R1 ready after clear", {31'h0, loc_tx_ready}, 32'h1);

        // R4/R5 a few bytes, mailbox freed after each
        cyc();
        for (int i = 0; i < 10; i++) begin
            h_send(8'hA0 + 8'(i));
            chk(host_mb_rdata == 0, "R5 mailbox freed", host_mb_rdata, 32'h0);
        end
        pop_n(10);
        @(negedge clk);
        chk(loc_rd_avail == 0, "R4 drained", {31'h0, loc_rd_avail}, 32'h0);

        // R9 unknown code leaves mailbox and buffer untouched
        cyc();
        host_mb_we = 1; host_mb_wdata = 32'h8000_00AA; cyc(); host_mb_we = 0;
        h_bell(32'h7);
        @(negedge clk);
        chk(proto_err == 1, "R9 err set", {31'h0, proto_err}, 32'h1);
        chk(host_mb_rdata == 32'h8000_00AA, "R9 mailbox kept", host_mb_rdata, 32'h8000_00AA);
        chk(loc_rd_avail == 0, "R9 no store", {31'h0, loc_rd_avail}, 32'h0);
        // R3 connect zeroes mailbox
        cyc();
        h_bell(32'h2);
        @(negedge clk);
        chk(host_mb_rdata == 0, "R3 mailbox zeroed", host_mb_rdata, 32'h0);

        // R5/R6 fill to the threshold
        cyc();
        for (int i = 0; i < 253; i++) begin
            h_send(8'(i));
            if (i < 252) chk(host_mb_rdata == 0, "R5 below limit freed", host_mb_rdata, 32'h0);
        end
        @(negedge clk);
        chk(host_mb_rdata == 32'h8000_00FC, "R5 held above limit", host_mb_rdata, 32'h8000_00FC);
        cyc();
        pop_n(1);
        @(negedge clk);
        chk(host_mb_rdata != 0, "R6 still held at 252", host_mb_rdata, 32'h8000_00FC);
        cyc();
        pop_n(1);
        @(negedge clk);
        chk(host_mb_rdata == 0, "R6 released at 251", host_mb_rdata, 32'h0);
        cyc();
        pop_n(251);
        @(negedge clk);
        chk(loc_rd_avail == 0 && sb_q.size() == 0, "R4 wrap drained", {31'h0, loc_rd_avail}, 32'h0);

        // R3 connect discards stored bytes
        cyc();
        for (int i = 0; i < 3; i++) h_send(8'h30 + 8'(i));
        h_bell(32'h2);
        sb_q.delete();
        @(negedge clk);
        chk(loc_rd_avail == 0, "R3 buffer emptied", {31'h0, loc_rd_avail}, 32'h0);
        cyc();
        h_send(8'h5A);
        pop_n(1);
        @(negedge clk);
        chk(sb_q.size() == 0, "R3 fresh byte after connect", sb_q.size(), 32'h0);

        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule